// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when a processor core may leave its normal instruction stream to service a maskable interrupt. It then carries out the core's entry into the service routine and later its exit, one memory cycle at a time. Each request source has an event flag, which hardware sets and software clears, and a local enable. A global mask bit, set out of reset, blocks every maskable source. A software-interrupt command takes the same entry path and ignores the mask. A return command unwinds the saved state. The memory and the core's register file lie outside the block: memory is a byte-wide port with a combinational read, and the core supplies its current registers and takes restored values back as load pulses.

Entry takes eleven busy cycles. The block writes five register bytes onto a descending stack and sets the mask. It then reads a two-byte vector and reads three instruction bytes from the vector address, which it offers to the core's fetch queue. At the end it loads the new program counter and stack pointer. A return takes six busy cycles: five pops in reverse order, then a load of the restored registers. The upper index byte is never saved or restored. A source that is still flagged and enabled when the restored mask reads zero is serviced again at the next instruction boundary.

The controller has eight states. S_IDLE waits for a boundary. S_PUSH runs five stack writes. S_VECH and S_VECL read the vector's high and low bytes. S_FILL runs three queue reads. S_EDONE loads the entry results. S_POP runs five stack reads. S_RDONE loads the return results. The transitions are as follows. S_IDLE goes to S_POP on a return command, and to S_PUSH on a software command or an accepted hardware request. S_PUSH goes to S_VECH after its fifth write. S_VECH goes to S_VECL, and S_VECL goes to S_FILL. S_FILL goes to S_EDONE after its third read. S_POP goes to S_RDONE after its fifth read. S_EDONE and S_RDONE both go back to S_IDLE.

Top module: `intr_sequencer`

## Requirements
- R1: After reset, busy is 0, mask is 1, all flags are 0, all local enables are 0, and mem_wr and mem_rd are 0.
- R2: A 1 on evt[n] sets flags[n] at the next edge. A 1 on flag_clr[n] clears it. When both arrive in the same cycle, the flag is set.
- R3: A hardware request is taken only when all of the following hold: the block is idle, insn_done is 1, mask is 0, and some source has both its flag and its enable at 1. No request is taken while insn_done is 0.
- R4: Entry makes exactly five stack writes, at SP, SP-1, SP-2, SP-3 and SP-4, where SP is cpu_sp at the boundary. The bytes written are, in order, PC[7:0], PC[15:8], X, A and CCR. In the stacked CCR, bit 3 holds the mask value from before entry. No upper index byte is written.
- R5: The mask is 1 from the first vector read onward.
- R6: The vector for hardware source n is read at VEC_BASE-2n (high byte) and VEC_BASE-2n+1 (low byte). The software vector is read at SWI_VEC and SWI_VEC+1.
- R7: After the vector, three reads at V, V+1 and V+2 are presented on q_byte with q_idx 0, 1 and 2. The next cycle pulses pc_load with pc_out=V and sp_load with sp_out=SP-5.
- R8: A software command at a boundary runs the same entry sequence even when the mask is 1. A return command takes precedence over a software command, and a software command takes precedence over a hardware request.
- R9: A return makes five reads at SP+1 through SP+5 into CCR, A, X, PC[15:8] and PC[7:0]. The next cycle pulses regs_load, pc_load and sp_load with those values and sp_out=SP+5. The mask takes bit 3 of the popped CCR.
- R10: busy is 1 for exactly 11 cycles per entry and 6 per return. While busy, the inputs insn_done, swi_req, rti_req, mask_set and mask_clr have no effect.
- R11: When several qualified sources are pending, the lowest-numbered source is serviced.
- R12: If a source is still flagged and enabled after a return that restores the mask to 0, the next boundary starts a new entry for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | NSRC | Per-source event pulses |
| flag_clr | input | NSRC | Write 1 to clear a flag |
| en_we | input | 1 | Load the local enables |
| en_wdata | input | NSRC | New local enable values |
| flags | output | NSRC | Per-source event flags |
| mask_set | input | 1 | Set the global mask (only when idle) |
| mask_clr | input | 1 | Clear the global mask (only when idle) |
| mask | output | 1 | Global mask bit |
| insn_done | input | 1 | Current instruction has completed |
| swi_req | input | 1 | Software interrupt command |
| rti_req | input | 1 | Return command |
| cpu_pc | input | 16 | Core program counter |
| cpu_a | input | 8 | Core accumulator |
| cpu_x | input | 8 | Core index low byte |
| cpu_ccr | input | 8 | Core condition codes |
| cpu_sp | input | 16 | Core stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| q_valid | output | 1 | Queue byte valid |
| q_idx | output | 2 | Queue slot 0..2 |
| q_byte | output | 8 | Queue byte |
| pc_load | output | 1 | Load pc_out into the core |
| pc_out | output | 16 | New program counter |
| regs_load | output | 1 | Load a_out, x_out and ccr_out |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored index low byte |
| ccr_out | output | 8 | Restored condition codes |
| sp_load | output | 1 | Load sp_out into the core |
| sp_out | output | 16 | New stack pointer |
| busy | output | 1 | A sequence is in progress |

## Verification
Some behaviour is checked by properties on every cycle: flag setting and clearing, the lowest-index choice of the priority encoder, the rule that no hardware entry starts without a boundary and a clear mask, the mask being set during the vector reads, and the step-by-one stack addresses during pushes and pops. The directed scenarios cover the rest. They check the byte order and data on the stack, the vector and queue addresses, the restored register values and mask, and the exact busy lengths. They also check the precedence between return and software commands, that commands arriving during a sequence have no effect, and that a still-pending source is serviced again after a return.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
    localparam int ADDR_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int MASK_BIT = 3;
    localparam int N_STACK  = 5;
    localparam int N_QUEUE  = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_VECH,
        S_VECL,
        S_FILL,
        S_EDONE,
        S_POP,
        S_RDONE
    } seq_state_t;
endpackage

// File: rtl/intr_src_bank.sv
module intr_src_bank #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] flag_clr,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] qual
);
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | evt;
            if (en_we) begin
                en_q <= en_wdata;
            end
        end
    end

    assign flags = flag_q;
    assign qual  = flag_q & en_q;

    // R2: an event is always captured
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    // R2: a clear without a simultaneous event empties the flag
    p_flag_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr & ~evt) != '0) |=> ((flags & $past(flag_clr & ~evt)) == '0));
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
    parameter int NSRC = 4,
    parameter int IW   = 2
) (
    input  logic [NSRC-1:0] req,
    output logic            valid,
    output logic [IW-1:0]   idx
);
    logic [NSRC:0]   seen;
    logic [NSRC-1:0] grant;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

    assign valid = seen[NSRC];
endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int                NSRC     = 4,
    parameter int                IW       = 2,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF8,
    parameter logic [ADDR_W-1:0] SWI_VEC  = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              swi_req,
    input  logic              rti_req,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              hw_valid,
    input  logic [IW-1:0]     hw_idx,
    input  logic [ADDR_W-1:0] cpu_pc,
    input  logic [BYTE_W-1:0] cpu_a,
    input  logic [BYTE_W-1:0] cpu_x,
    input  logic [BYTE_W-1:0] cpu_ccr,
    input  logic [ADDR_W-1:0] cpu_sp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_rd,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              q_valid,
    output logic [1:0]        q_idx,
    output logic [BYTE_W-1:0] q_byte,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_out,
    output logic              regs_load,
    output logic [BYTE_W-1:0] a_out,
    output logic [BYTE_W-1:0] x_out,
    output logic [BYTE_W-1:0] ccr_out,
    output logic              sp_load,
    output logic [ADDR_W-1:0] sp_out,
    output logic              mask,
    output logic              busy
);
    localparam logic [2:0]        LAST_STK = 3'(N_STACK - 1);
    localparam logic [2:0]        LAST_Q   = 3'(N_QUEUE - 1);
    localparam logic [BYTE_W-1:0] MBIT     = BYTE_W'(1) << MASK_BIT;

    seq_state_t        state_q, state_d;
    logic [2:0]        cnt_q;
    logic [ADDR_W-1:0] sp_q, vaddr_q, vec_q, pc_l;
    logic [BYTE_W-1:0] a_l, x_l, ccr_l;
    logic              mask_q;
    logic              take_rti, take_swi, take_hw, take_any;

    always_comb begin
        take_rti = (state_q == S_IDLE) && insn_done && rti_req;
        take_swi = (state_q == S_IDLE) && insn_done && !rti_req && swi_req;
        take_hw  = (state_q == S_IDLE) && insn_done && !rti_req && !swi_req
                   && hw_valid && !mask_q;
        take_any = take_rti || take_swi || take_hw;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take_rti) begin
                    state_d = S_POP;
                end else if (take_swi || take_hw) begin
                    state_d = S_PUSH;
                end
            end
            S_PUSH:  if (cnt_q == LAST_STK) state_d = S_VECH;
            S_VECH:  state_d = S_VECL;
            S_VECL:  state_d = S_FILL;
            S_FILL:  if (cnt_q == LAST_Q) state_d = S_EDONE;
            S_EDONE: state_d = S_IDLE;
            S_POP:   if (cnt_q == LAST_STK) state_d = S_RDONE;
            S_RDONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? 3'd0 : cnt_q + 3'd1;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q    <= '0;
            vaddr_q <= '0;
            vec_q   <= '0;
            pc_l    <= '0;
            a_l     <= '0;
            x_l     <= '0;
            ccr_l   <= '0;
            mask_q  <= 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (take_any) begin
                        sp_q    <= cpu_sp;
                        pc_l    <= cpu_pc;
                        a_l     <= cpu_a;
                        x_l     <= cpu_x;
                        ccr_l   <= (cpu_ccr & ~MBIT) | (BYTE_W'(mask_q) << MASK_BIT);
                        vaddr_q <= take_swi ? SWI_VEC
                                            : VEC_BASE - (ADDR_W'(hw_idx) << 1);
                    end else if (mask_set) begin
                        mask_q <= 1'b1;
                    end else if (mask_clr) begin
                        mask_q <= 1'b0;
                    end
                end
                S_PUSH: begin
                    sp_q <= sp_q - 1'b1;
                    if (cnt_q == LAST_STK) begin
                        mask_q <= 1'b1;
                    end
                end
                S_VECH: vec_q[ADDR_W-1:BYTE_W] <= mem_rdata;
                S_VECL: vec_q[BYTE_W-1:0]      <= mem_rdata;
                S_POP: begin
                    sp_q <= sp_q + 1'b1;
                    unique case (cnt_q)
                        3'd0: begin
                            ccr_l  <= mem_rdata;
                            mask_q <= mem_rdata[MASK_BIT];
                        end
                        3'd1:    a_l <= mem_rdata;
                        3'd2:    x_l <= mem_rdata;
                        3'd3:    pc_l[ADDR_W-1:BYTE_W] <= mem_rdata;
                        default: pc_l[BYTE_W-1:0]      <= mem_rdata;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr  = sp_q;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        mem_rd    = 1'b0;
        q_valid   = 1'b0;
        q_idx     = cnt_q[1:0];
        q_byte    = '0;
        pc_load   = 1'b0;
        pc_out    = vec_q;
        regs_load = 1'b0;
        sp_load   = 1'b0;
        unique case (state_q)
            S_PUSH: begin
                mem_wr = 1'b1;
                unique case (cnt_q)
                    3'd0:    mem_wdata = pc_l[BYTE_W-1:0];
                    3'd1:    mem_wdata = pc_l[ADDR_W-1:BYTE_W];
                    3'd2:    mem_wdata = x_l;
                    3'd3:    mem_wdata = a_l;
                    default: mem_wdata = ccr_l;
                endcase
            end
            S_VECH: begin
                mem_rd   = 1'b1;
                mem_addr = vaddr_q;
            end
            S_VECL: begin
                mem_rd   = 1'b1;
                mem_addr = vaddr_q + 1'b1;
            end
            S_FILL: begin
                mem_rd   = 1'b1;
                mem_addr = vec_q + ADDR_W'(cnt_q);
                q_valid  = 1'b1;
                q_byte   = mem_rdata;
            end
            S_EDONE: begin
                pc_load = 1'b1;
                sp_load = 1'b1;
            end
            S_POP: begin
                mem_rd   = 1'b1;
                mem_addr = sp_q + 1'b1;
            end
            S_RDONE: begin
                regs_load = 1'b1;
                pc_load   = 1'b1;
                pc_out    = pc_l;
                sp_load   = 1'b1;
            end
            default: ;
        endcase
    end

    assign a_out   = a_l;
    assign x_out   = x_l;
    assign ccr_out = ccr_l;
    assign sp_out  = sp_q;
    assign mask    = mask_q;
    assign busy    = (state_q != S_IDLE);

    // R5: the mask is already set when the vector is read
    p_mask_at_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VECH) |-> mask_q);

    // R3: a stacking sequence starts only at a boundary with a legal request
    p_entry_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PUSH && $past(state_q) == S_IDLE)
            |-> ($past(insn_done) && ($past(swi_req) || !$past(mask_q))));

    // R4: consecutive stack writes walk downward by one
    p_push_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - 1'b1));

    // R9: consecutive pops walk upward by one
    p_pop_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP && $past(state_q) == S_POP)
            |-> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
    import intr_seq_pkg::*;
#(
    parameter int          NSRC     = 4,
    parameter logic [15:0] VEC_BASE = 16'hFFF8,
    parameter logic [15:0] SWI_VEC  = 16'hFFFC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] flag_clr,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] flags,
    input  logic            mask_set,
    input  logic            mask_clr,
    output logic            mask,
    input  logic            insn_done,
    input  logic            swi_req,
    input  logic            rti_req,
    input  logic [15:0]     cpu_pc,
    input  logic [7:0]      cpu_a,
    input  logic [7:0]      cpu_x,
    input  logic [7:0]      cpu_ccr,
    input  logic [15:0]     cpu_sp,
    output logic [15:0]     mem_addr,
    output logic            mem_wr,
    output logic [7:0]      mem_wdata,
    output logic            mem_rd,
    input  logic [7:0]      mem_rdata,
    output logic            q_valid,
    output logic [1:0]      q_idx,
    output logic [7:0]      q_byte,
    output logic            pc_load,
    output logic [15:0]     pc_out,
    output logic            regs_load,
    output logic [7:0]      a_out,
    output logic [7:0]      x_out,
    output logic [7:0]      ccr_out,
    output logic            sp_load,
    output logic [15:0]     sp_out,
    output logic            busy
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] qual;
    logic            hw_valid;
    logic [IW-1:0]   hw_idx;

    intr_src_bank #(.NSRC(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .flag_clr (flag_clr),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .flags    (flags),
        .qual     (qual)
    );

    intr_prio_enc #(.NSRC(NSRC), .IW(IW)) u_prio (
        .req   (qual),
        .valid (hw_valid),
        .idx   (hw_idx)
    );

    intr_seq_fsm #(
        .NSRC     (NSRC),
        .IW       (IW),
        .VEC_BASE (VEC_BASE),
        .SWI_VEC  (SWI_VEC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .swi_req   (swi_req),
        .rti_req   (rti_req),
        .mask_set  (mask_set),
        .mask_clr  (mask_clr),
        .hw_valid  (hw_valid),
        .hw_idx    (hw_idx),
        .cpu_pc    (cpu_pc),
        .cpu_a     (cpu_a),
        .cpu_x     (cpu_x),
        .cpu_ccr   (cpu_ccr),
        .cpu_sp    (cpu_sp),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .q_valid   (q_valid),
        .q_idx     (q_idx),
        .q_byte    (q_byte),
        .pc_load   (pc_load),
        .pc_out    (pc_out),
        .regs_load (regs_load),
        .a_out     (a_out),
        .x_out     (x_out),
        .ccr_out   (ccr_out),
        .sp_load   (sp_load),
        .sp_out    (sp_out),
        .mask      (mask),
        .busy      (busy)
    );

    // R11: the chosen source is qualified and no lower index is
    p_prio_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid |-> (qual[hw_idx] &&
            ((qual & ((NSRC'(1) << hw_idx) - NSRC'(1))) == '0)));
endmodule

// File: tb/intr_sequencer_test.sv
module intr_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] evt = '0, flag_clr = '0, en_wdata = '0, flags;
    logic en_we = 0, mask_set = 0, mask_clr = 0, mask;
    logic insn_done = 0, swi_req = 0, rti_req = 0;
    logic [15:0] cpu_pc = 16'h1234, cpu_sp = 16'h01F0;
    logic [7:0]  cpu_a = 8'h56, cpu_x = 8'h78, cpu_ccr = 8'hC0;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic mem_wr, mem_rd, q_valid, pc_load, regs_load, sp_load, busy;
    logic [7:0] mem_wdata, mem_rdata, q_byte, a_out, x_out, ccr_out;
    logic [1:0] q_idx;

    int nchk = 0, nerr = 0;
    int wn = 0, qn = 0, npl = 0, nrl = 0, nbusy = 0;
    logic [15:0] waddr [8];
    logic [7:0]  wdat [8];
    logic [7:0]  qlog [4];
    logic [15:0] last_pc, last_sp;
    logic [7:0]  last_a, last_x, last_ccr;
    logic [7:0]  stk [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_sequencer uut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .flag_clr(flag_clr),
        .en_we(en_we), .en_wdata(en_wdata), .flags(flags),
        .mask_set(mask_set), .mask_clr(mask_clr), .mask(mask),
        .insn_done(insn_done), .swi_req(swi_req), .rti_req(rti_req),
        .cpu_pc(cpu_pc), .cpu_a(cpu_a), .cpu_x(cpu_x), .cpu_ccr(cpu_ccr),
        .cpu_sp(cpu_sp), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .q_valid(q_valid), .q_idx(q_idx), .q_byte(q_byte),
        .pc_load(pc_load), .pc_out(pc_out), .regs_load(regs_load),
        .a_out(a_out), .x_out(x_out), .ccr_out(ccr_out),
        .sp_load(sp_load), .sp_out(sp_out), .busy(busy)
    );

    // memory model: page 0x01 is stack RAM, other addresses return addr^0x5A
    always_comb begin
        if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else                         mem_rdata = mem_addr[7:0] ^ 8'h5A;
    end

    always @(posedge clk) begin
        if (mem_wr) begin
            if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] = mem_wdata;
            if (wn < 8) begin
                waddr[wn] = mem_addr;
                wdat[wn]  = mem_wdata;
            end
            wn++;
        end
        if (q_valid) begin
            qlog[q_idx] = q_byte;
            qn++;
        end
        if (pc_load) begin
            last_pc = pc_out;
            npl++;
        end
        if (sp_load) last_sp = sp_out;
        if (regs_load) begin
            last_a = a_out; last_x = x_out; last_ccr = ccr_out;
            nrl++;
        end
        if (busy) nbusy++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_logs();
        wn = 0; qn = 0; npl = 0; nrl = 0; nbusy = 0;
    endtask

    task automatic boundary(input logic s, input logic r);
        @(negedge clk);
        insn_done = 1; swi_req = s; rti_req = r;
        @(negedge clk);
        insn_done = 0; swi_req = 0; rti_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_mask(input logic set);
        @(negedge clk);
        mask_set = set; mask_clr = !set;
        @(negedge clk);
        mask_set = 0; mask_clr = 0;
    endtask

    task automatic pulse_evt(input logic [N-1:0] e, input logic [N-1:0] c);
        @(negedge clk);
        evt = e; flag_clr = c;
        @(negedge clk);
        evt = '0; flag_clr = '0;
    endtask

    task automatic set_en(input logic [N-1:0] v);
        @(negedge clk);
        en_we = 1; en_wdata = v;
        @(negedge clk);
        en_we = 0;
    endtask

    task automatic t_reset();
        chk(busy == 0, "R1 busy", busy, 0);
        chk(mask == 1, "R1 mask", mask, 1);
        chk(flags == 0, "R1 flags", flags, 0);
        chk(!mem_wr && !mem_rd, "R1 mem idle", {mem_wr, mem_rd}, 0);
    endtask

    task automatic t_flag_rules();
        pulse_evt(4'b0001, 4'b0000);
        chk(flags == 4'b0001, "R2 set", flags, 4'b0001);
        pulse_evt(4'b0001, 4'b0001);
        chk(flags == 4'b0001, "R2 set wins", flags, 4'b0001);
        pulse_evt(4'b0000, 4'b0001);
        chk(flags == 4'b0000, "R2 clear", flags, 0);
    endtask

    task automatic t_gating();
        // enables reset to 0 (R1): flagged source with no enable is not taken
        pulse_evt(4'b0001, 4'b0000);
        pulse_mask(0);
        boundary(0, 0);
        chk(busy == 0, "R1 R3 disabled source ignored", busy, 0);
        pulse_evt(4'b0000, 4'b0001);
        set_en(4'b0010);
        pulse_evt(4'b0010, 4'b0000);
        pulse_mask(1);
        boundary(0, 0);
        chk(busy == 0, "R3 masked request ignored", busy, 0);
        pulse_mask(0);
        repeat (5) @(negedge clk);
        chk(busy == 0, "R3 no boundary no entry", busy, 0);
    endtask

    task automatic t_hw_entry();
        clr_logs();
        boundary(0, 0);
        wait_idle();
        chk(wn == 5, "R4 write count", wn, 5);
        chk(waddr[0] == 16'h01F0 && wdat[0] == 8'h34, "R4 PCL", {waddr[0], wdat[0]}, 24'h01F034);
        chk(waddr[1] == 16'h01EF && wdat[1] == 8'h12, "R4 PCH", {waddr[1], wdat[1]}, 24'h01EF12);
        chk(waddr[2] == 16'h01EE && wdat[2] == 8'h78, "R4 X", {waddr[2], wdat[2]}, 24'h01EE78);
        chk(waddr[3] == 16'h01ED && wdat[3] == 8'h56, "R4 A", {waddr[3], wdat[3]}, 24'h01ED56);
        chk(waddr[4] == 16'h01EC && wdat[4] == 8'hC0, "R4 CCR", {waddr[4], wdat[4]}, 24'h01ECC0);
        chk(mask == 1, "R5 mask set", mask, 1);
        chk(last_pc == 16'hACAD, "R6 vector src1", last_pc, 16'hACAD);
        chk(qn == 3 && qlog[0] == 8'hF7 && qlog[1] == 8'hF4 && qlog[2] == 8'hF5,
            "R7 queue", {qlog[0], qlog[1], qlog[2]}, 24'hF7F4F5);
        chk(last_sp == 16'h01EB, "R7 sp", last_sp, 16'h01EB);
        chk(nbusy == 11, "R10 entry length", nbusy, 11);
    endtask

    task automatic t_return_reentry();
        cpu_sp = 16'h01EB; cpu_pc = 16'hBEEF; cpu_a = 0; cpu_x = 0; cpu_ccr = 0;
        clr_logs();
        boundary(0, 1);
        @(negedge clk); mask_set = 1;  // during pops: must be ignored (R10)
        @(negedge clk); mask_set = 0;
        wait_idle();
        chk(nrl == 1 && wn == 0, "R9 return load", {nrl[7:0], wn[7:0]}, 16'h0100);
        chk(last_a == 8'h56 && last_x == 8'h78 && last_ccr == 8'hC0, "R9 regs",
            {last_a, last_x, last_ccr}, 24'h5678C0);
        chk(last_pc == 16'h1234 && last_sp == 16'h01F0, "R9 pc sp", {last_pc, last_sp}, 32'h123401F0);
        chk(mask == 0, "R9 R10 mask from stacked CCR", mask, 0);
        chk(nbusy == 6, "R10 return length", nbusy, 6);
        cpu_sp = 16'h01F0; cpu_pc = 16'h1234; cpu_a = 8'h56; cpu_x = 8'h78; cpu_ccr = 8'hC0;
        clr_logs();
        boundary(0, 0);
        wait_idle();
        chk(wn == 5 && last_pc == 16'hACAD, "R12 pending source re-entered", last_pc, 16'hACAD);
        pulse_evt(4'b0000, 4'b0010);
        cpu_sp = 16'h01EB;
        boundary(0, 1);
        wait_idle();
        cpu_sp = 16'h01F0;
        clr_logs();
        boundary(0, 0);
        chk(busy == 0 && mask == 0, "R2 R12 cleared source not re-entered", busy, 0);
    endtask

    task automatic t_priority();
        pulse_mask(1);
        set_en(4'b1110);
        pulse_evt(4'b1100, 4'b0000);
        pulse_mask(0);
        clr_logs();
        boundary(0, 0);
        wait_idle();
        chk(last_pc == 16'hAEAF, "R11 lowest index wins", last_pc, 16'hAEAF);
        pulse_evt(4'b0000, 4'b1111);
        cpu_sp = 16'h01EB;
        boundary(0, 1);
        wait_idle();
        cpu_sp = 16'h01F0;
    endtask

    task automatic t_swi_busy();
        pulse_mask(1);
        clr_logs();
        boundary(1, 0);
        @(negedge clk);
        insn_done = 1; rti_req = 1; mask_clr = 1;
        @(negedge clk);
        insn_done = 0; rti_req = 0; mask_clr = 0;
        wait_idle();
        chk(wn == 5 && wdat[4] == 8'hC8, "R8 swi under mask, CCR bit3", wdat[4], 8'hC8);
        chk(last_pc == 16'hA6A7, "R6 R8 swi vector", last_pc, 16'hA6A7);
        chk(qlog[0] == 8'hFD && qlog[1] == 8'hF2 && qlog[2] == 8'hF3, "R7 swi queue",
            {qlog[0], qlog[1], qlog[2]}, 24'hFDF2F3);
        chk(nrl == 0 && nbusy == 11 && mask == 1, "R10 commands ignored while busy",
            {nrl[7:0], nbusy[7:0]}, 16'h000B);
    endtask

    task automatic t_rti_precedence();
        cpu_sp = 16'h01EB;
        clr_logs();
        boundary(1, 1);
        wait_idle();
        chk(wn == 0 && nrl == 1, "R8 return beats swi", {wn[7:0], nrl[7:0]}, 16'h0001);
        chk(last_ccr == 8'hC8 && mask == 1, "R9 mask restored to 1", {last_ccr, 7'b0, mask}, 16'hC801);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flag_rules();
        t_gating();
        t_hw_entry();
        t_return_reentry();
        t_priority();
        t_swi_busy();
        t_rti_precedence();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule